// File: doc/BRIEF.md
# Flash Block-Protect Range Checker

This block checks write and erase requests against the block-protect setting of an 8 MB serial flash array. The array has 128 sectors of 64 KB each. A three-bit protect code and a direction bit select the protected region. The region size in sectors doubles with each step of the code. The region sits either against the top of the array or against address zero. Each request carries an operation (program, sector erase or bulk erase) and a 24-bit address. One cycle after it is accepted, the block gives a one-cycle verdict: either accepted or rejected.

The protected window is held in registers and driven out as an inclusive start and end byte address, so that it can be observed. Requests use a valid/ready handshake. The block never applies back-pressure: ready is low only while reset is asserted and is high on every cycle after that. Each cycle in which valid and ready are both high is exactly one request, and each request gets its verdict exactly one cycle later. There is no buffering, so back-to-back requests give back-to-back verdicts. Requests are always judged against the window held in the registers at that clock edge.

Top module: `flash_prot_checker`

## Requirements
- R1: While reset is asserted, req_ready, prot_en, op_accept and op_reject are 0 and prot_lo and prot_hi are 000000h. From the first clock edge after reset is released, req_ready is 1.
- R2: A protect code of 0 protects nothing: prot_en is 0, prot_lo and prot_hi are 000000h, and every program, sector erase and bulk erase is accepted.
- R3: With prot_from_bottom = 0 and a code n from 1 to 6, the window covers the top 2^n sectors: prot_lo = 800000h - n_sect*10000h and prot_hi = 7FFFFFh. For example, code 1 gives 7E0000h and code 4 gives 700000h.
- R4: With prot_from_bottom = 1 and a code n from 1 to 6, the window covers the lowest 2^n sectors: prot_lo = 000000h and prot_hi = 2^n*10000h - 1.
- R5: Code 7 protects the whole array in either direction: prot_lo = 000000h and prot_hi = 7FFFFFh.
- R6: prot_lo, prot_hi and prot_en change on the first clock edge after the protect inputs change. A request presented in the same cycle as a change is judged against the window as it was before the change.
- R7: A program (req_op = 00) or sector erase (req_op = 01) whose address lies inside [prot_lo, prot_hi] while prot_en is 1 produces op_reject. Any other program or sector erase produces op_accept.
- R8: A bulk erase (req_op = 10) is rejected whenever the protect code is non-zero and accepted when it is 0. Its address has no effect.
- R9: Address bit 23 is ignored. The address wraps onto the 8 MB array, so FF0000h is judged as 7F0000h.
- R10: The reserved operation code 11 produces neither op_accept nor op_reject.
- R11: Each accepted request gives exactly one one-cycle pulse on op_accept or op_reject, on the clock edge that samples the request. The two pulses are never high together, and neither is high without a request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_code | input | 3 | Block-protect code; 0 means no protection |
| prot_from_bottom | input | 1 | 0 = window grows down from the top, 1 = window grows up from zero |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block accepts requests; high on every cycle after reset |
| req_op | input | 2 | 00 program, 01 sector erase, 10 bulk erase, 11 reserved |
| req_addr | input | 24 | Target byte address; bit 23 ignored |
| op_accept | output | 1 | One-cycle pulse: the last request may proceed |
| op_reject | output | 1 | One-cycle pulse: the last request is blocked |
| prot_en | output | 1 | Registered: a protected window exists |
| prot_lo | output | 24 | Registered first protected byte address |
| prot_hi | output | 24 | Registered last protected byte address |

## Verification
Both the window outputs and the verdict pulses come one register after their cause. A protect setting changed before one clock edge can be read on prot_lo, prot_hi and prot_en after that edge. A request presented before an edge has its verdict on op_accept or op_reject after the same edge, and the pulse is gone one edge later. The bench drives every input on the falling clock edge. It reads results on the next falling edge, which lies exactly one rising edge after the stimulus. To check the pulse width and the same-cycle ordering, it also reads one falling edge later, where every pulse must be low again. When a request is meant to see a new window, the bench first waits one full cycle after changing the protect inputs.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

  // Operation codes carried on req_op
  typedef enum logic [1:0] {
    OP_PROG       = 2'b00,
    OP_SECT_ERASE = 2'b01,
    OP_BULK_ERASE = 2'b10,
    OP_RSVD       = 2'b11
  } flash_op_e;

endpackage

// File: rtl/prot_span_decode.sv
// Turns a protect code and direction into an inclusive byte window.
module prot_span_decode #(
  parameter int CODE_W     = 3,
  parameter int SECT_LOG2  = 16,
  parameter int NSECT_LOG2 = 7,
  parameter int ADDR_W     = 24
) (
  input  logic [CODE_W-1:0] code,
  input  logic              from_bottom,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi
);
  localparam int AW = SECT_LOG2 + NSECT_LOG2;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [AW:0] ARRAY_SIZE = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] ARRAY_LAST = {1'b0, {AW{1'b1}}};
  localparam logic [AW:0] ONE        = {{AW{1'b0}}, 1'b1};

  logic          full;
  int            sh;
  logic [AW:0]   span;
  logic [AW:0]   lo_a;
  logic [AW:0]   hi_a;

  always_comb begin
    full = (code == CODE_MAX) || (int'(code) >= NSECT_LOG2);
    sh   = full ? AW : int'(code) + SECT_LOG2;
    span = ONE << sh;
    if (code == '0) begin
      lo_a = '0;
      hi_a = '0;
    end else if (from_bottom) begin
      lo_a = '0;
      hi_a = span - ONE;
    end else begin
      lo_a = ARRAY_SIZE - span;
      hi_a = ARRAY_LAST;
    end
  end

  assign win_en = (code != '0);
  assign win_lo = ADDR_W'(lo_a[AW-1:0]);
  assign win_hi = ADDR_W'(hi_a[AW-1:0]);

endmodule

// File: rtl/prot_range_reg.sv
// Holds the decoded window so it is stable and observable.
module prot_range_reg #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_d,
  input  logic [ADDR_W-1:0] lo_d,
  input  logic [ADDR_W-1:0] hi_d,
  output logic              en_q,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      en_q <= en_d;
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R3 R4 R5: a live window is never inverted
  p_window_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (lo_q <= hi_q));

  // R2: no window means both bounds rest at zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (lo_q == '0 && hi_q == '0));

endmodule

// File: rtl/prot_access_judge.sv
// Judges each handshaked request against the registered window.
module prot_access_judge
  import flash_prot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AW     = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              win_en,
  input  logic [AW-1:0]     win_lo,
  input  logic [AW-1:0]     win_hi,
  output logic              op_accept,
  output logic              op_reject
);
  logic          ready_q;
  logic [AW-1:0] addr_m;
  logic          in_win;
  logic          take;
  flash_op_e     op;

  generate
    if (ADDR_W > AW) begin : g_wrap
      logic unused_addr_hi;
      assign unused_addr_hi = ^req_addr[ADDR_W-1:AW];
    end
  endgenerate

  assign addr_m    = req_addr[AW-1:0];
  assign in_win    = win_en && (addr_m >= win_lo) && (addr_m <= win_hi);
  assign take      = req_valid && ready_q;
  assign op        = flash_op_e'(req_op);
  assign req_ready = ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      op_accept <= 1'b0;
      op_reject <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      op_accept <= 1'b0;
      op_reject <= 1'b0;
      if (take) begin
        unique case (op)
          OP_PROG, OP_SECT_ERASE: begin
            op_reject <= in_win;
            op_accept <= !in_win;
          end
          OP_BULK_ERASE: begin
            op_reject <= win_en;
            op_accept <= !win_en;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: verdicts are exclusive
  p_verdict_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_accept && op_reject));

  // R11: no verdict without a request one cycle before
  p_verdict_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept || op_reject) |-> $past(req_valid && req_ready));

  // R8: bulk erase under any protection is rejected
  p_bulk_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b10 && win_en) |=> op_reject);

  // R10: reserved code gives no verdict
  p_rsvd_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> !(op_accept || op_reject));

endmodule

// File: rtl/flash_prot_checker.sv
module flash_prot_checker #(
  parameter int CODE_W     = 3,
  parameter int SECT_LOG2  = 16,
  parameter int NSECT_LOG2 = 7,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] prot_code,
  input  logic              prot_from_bottom,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              op_accept,
  output logic              op_reject,
  output logic              prot_en,
  output logic [ADDR_W-1:0] prot_lo,
  output logic [ADDR_W-1:0] prot_hi
);
  localparam int AW = SECT_LOG2 + NSECT_LOG2;
  localparam logic [CODE_W-1:0] CODE_MAX  = '1;
  localparam logic [ADDR_W-1:0] ARRAY_END = ADDR_W'({AW{1'b1}});

  logic              en_d;
  logic [ADDR_W-1:0] lo_d;
  logic [ADDR_W-1:0] hi_d;

  prot_span_decode #(
    .CODE_W(CODE_W), .SECT_LOG2(SECT_LOG2),
    .NSECT_LOG2(NSECT_LOG2), .ADDR_W(ADDR_W)
  ) u_decode (
    .code(prot_code), .from_bottom(prot_from_bottom),
    .win_en(en_d), .win_lo(lo_d), .win_hi(hi_d)
  );

  prot_range_reg #(.ADDR_W(ADDR_W)) u_range (
    .clk(clk), .rst_n(rst_n),
    .en_d(en_d), .lo_d(lo_d), .hi_d(hi_d),
    .en_q(prot_en), .lo_q(prot_lo), .hi_q(prot_hi)
  );

  generate
    if (ADDR_W > AW) begin : g_bound_spare
      logic unused_bound_hi;
      assign unused_bound_hi = ^{prot_lo[ADDR_W-1:AW], prot_hi[ADDR_W-1:AW]};
    end
  endgenerate

  prot_access_judge #(.ADDR_W(ADDR_W), .AW(AW)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr),
    .win_en(prot_en), .win_lo(prot_lo[AW-1:0]), .win_hi(prot_hi[AW-1:0]),
    .op_accept(op_accept), .op_reject(op_reject)
  );

  // R2 R6: zero code clears the window one edge later
  p_zero_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code == '0) |=> !prot_en);

  // R3: top-anchored window ends at the last byte
  p_top_anchor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code != '0 && !prot_from_bottom) |=> (prot_en && prot_hi == ARRAY_END));

  // R4: bottom-anchored window starts at zero
  p_bottom_anchor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code != '0 && prot_from_bottom) |=> (prot_en && prot_lo == '0));

  // R5: highest code covers the full array
  p_full_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code == CODE_MAX) |=> (prot_lo == '0 && prot_hi == ARRAY_END));

endmodule

// File: tb/flash_prot_checker_bench.sv
module flash_prot_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  prot_code = '0;
  logic        prot_from_bottom = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [23:0] req_addr = '0;
  logic        op_accept, op_reject, prot_en;
  logic [23:0] prot_lo, prot_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_prot_checker u_flash_prot_checker (
    .clk(clk), .rst_n(rst_n), .prot_code(prot_code),
    .prot_from_bottom(prot_from_bottom), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .op_accept(op_accept), .op_reject(op_reject), .prot_en(prot_en),
    .prot_lo(prot_lo), .prot_hi(prot_hi)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void exp_win(input int c, input bit b, output bit en,
                                  output logic [23:0] lo, output logic [23:0] hi);
    int bytes;
    bytes = ((c == 7) ? 128 : (1 << c)) * 65536;
    en = (c != 0);
    if (c == 0) begin lo = 24'h0; hi = 24'h0; end
    else if (b) begin lo = 24'h0; hi = 24'(bytes - 1); end
    else begin lo = 24'(8388608 - bytes); hi = 24'h7FFFFF; end
  endfunction

  // starts and ends at a falling edge; window valid on return
  task automatic set_prot(input int c, input bit b);
    prot_code = 3'(c);
    prot_from_bottom = b;
    @(negedge clk);
  endtask

  task automatic check_win(input int c, input bit b, input string tag);
    bit en; logic [23:0] lo, hi;
    exp_win(c, b, en, lo, hi);
    chk(prot_en == en, tag, "prot_en", 32'(prot_en), 32'(en));
    chk(prot_lo == lo, tag, "prot_lo", 32'(prot_lo), 32'(lo));
    chk(prot_hi == hi, tag, "prot_hi", 32'(prot_hi), 32'(hi));
  endtask

  task automatic do_req(input logic [1:0] op, input logic [23:0] a,
                        input bit exp_acc, input bit exp_rej, input string tag);
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(op_accept == exp_acc, tag, "op_accept", 32'(op_accept), 32'(exp_acc));
    chk(op_reject == exp_rej, tag, "op_reject", 32'(op_reject), 32'(exp_rej));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready in reset", 32'(req_ready), 0);
    chk(!prot_en && prot_lo == 0 && prot_hi == 0, "R1", "window in reset",
        32'(prot_hi), 0);
    chk(!op_accept && !op_reject, "R1", "verdict in reset",
        32'({op_accept, op_reject}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
  endtask

  task automatic t_no_protect();
    set_prot(0, 1'b0);
    check_win(0, 1'b0, "R2");
    do_req(2'b00, 24'h7FFFFF, 1, 0, "R2");
    do_req(2'b01, 24'h000000, 1, 0, "R2");
    do_req(2'b10, 24'h000000, 1, 0, "R2 R8");
  endtask

  task automatic t_sweep(input bit b);
    for (int c = 1; c <= 7; c++) begin
      bit en; logic [23:0] lo, hi;
      string tg;
      tg = (c == 7) ? "R5" : (b ? "R4" : "R3");
      set_prot(c, b);
      check_win(c, b, tg);
      exp_win(c, b, en, lo, hi);
      do_req(2'b00, lo, 0, 1, "R7");
      do_req(2'b01, hi, 0, 1, "R7");
      if (c != 7) begin
        if (b) do_req(2'b00, hi + 24'd1, 1, 0, "R7");
        else   do_req(2'b01, lo - 24'd1, 1, 0, "R7");
      end
    end
  endtask

  task automatic t_bulk();
    set_prot(3, 1'b1);
    do_req(2'b10, 24'h7FFFFF, 0, 1, "R8");
    set_prot(1, 1'b0);
    do_req(2'b10, 24'h000000, 0, 1, "R8");
    set_prot(0, 1'b0);
    do_req(2'b10, 24'h7F0000, 1, 0, "R8");
  endtask

  task automatic t_wrap();
    set_prot(1, 1'b0);
    do_req(2'b00, 24'hFF0000, 0, 1, "R9");
    do_req(2'b00, 24'h800000, 1, 0, "R9");
  endtask

  task automatic t_reserved();
    set_prot(7, 1'b0);
    do_req(2'b11, 24'h100000, 0, 0, "R10");
  endtask

  task automatic t_same_cycle();
    set_prot(0, 1'b0);
    prot_code = 3'd1;
    do_req(2'b00, 24'h7F0000, 1, 0, "R6 old window");
    check_win(1, 1'b0, "R6");
    do_req(2'b00, 24'h7F0000, 0, 1, "R6 new window");
  endtask

  task automatic t_back_to_back();
    set_prot(2, 1'b1);
    req_valid = 1'b1; req_op = 2'b00; req_addr = 24'h010000;
    @(negedge clk);
    chk(op_reject && !op_accept, "R11", "first of pair",
        32'({op_accept, op_reject}), 32'b01);
    req_addr = 24'h040000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(op_accept && !op_reject, "R11", "second of pair",
        32'({op_accept, op_reject}), 32'b10);
    @(negedge clk);
    chk(!op_accept && !op_reject, "R11", "pulse ends",
        32'({op_accept, op_reject}), 0);
  endtask

  initial begin
    t_reset();
    t_no_protect();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_bulk();
    t_wrap();
    t_reserved();
    t_same_cycle();
    t_back_to_back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule